// File: doc/BRIEF.md
# Slot Hotplug Event Register Block

This block tracks insertion and removal events for up to 32 expansion slots and exposes them to software through a small word-addressed register window. Each insert or remove event clears the whole event record, marks only the slot it names, and raises a one-cycle strobe. That strobe sets the hotplug bit of the general-purpose event status and causes the system control interrupt level to be evaluated again. Cold-plug insertions describe devices that are already present at boot, so they leave no trace.

Software reads the two bitmaps to find which slot changed. To request a detach, it writes an eject word: the lowest set bit of the written value selects the slot. The block turns that write into an eject request pulse that carries a slot index. A removable-slot mask is fixed at reset from a parameter listing the slots that cannot be hot-removed. This mask is read-only and gates every eject request. The detach itself and all configuration-space work happen elsewhere.

Top module: `slot_hp_regs`

## Requirements
- R1: After reset both bitmaps read zero, the removable mask reads the bitwise inverse of FIXED_MASK (0xFFFF_FFFC by default), and eject_req_o and gpe_set_o are low.
- R2: Word 0 holds the inserted-slot bitmap and word 1 holds the removed-slot bitmap. A write to either stores wdata_i, and a later read returns it.
- R3: Reads of word 2 (eject) and of words 4 to 7 return zero. Read data appears on rdata_o one cycle after rd_i.
- R4: Word 3 reads the removable mask. Writes to word 3 leave it unchanged.
- R5: An insert event (evt_kind_i = 1) clears both bitmaps and then sets only bit evt_slot_i of the inserted bitmap.
- R6: A remove event (evt_kind_i = 2) clears both bitmaps and then sets only bit evt_slot_i of the removed bitmap.
- R7: gpe_set_o is high for exactly the one cycle after each insert or remove event, and low otherwise.
- R8: A cold-plug event (evt_kind_i = 3) changes neither bitmap and raises no gpe_set_o.
- R9: A write to word 2 selects the slot given by the lowest set bit of wdata_i. In the following cycle eject_req_o pulses with eject_slot_o equal to that slot.
- R10: No eject request is made when the selected slot is cleared in the removable mask, even if higher bits of the written value are set.
- R11: A write of zero to word 2 makes no eject request.
- R12: When an insert or remove event and a software write to a bitmap happen in the same cycle, the event result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_valid_i | input | 1 | Slot event present this cycle |
| evt_kind_i | input | 2 | Event kind: 1 insert, 2 remove, 3 cold-plug |
| evt_slot_i | input | 5 | Slot number of the event |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Word index in the register window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after rd_i |
| eject_req_o | output | 1 | One-cycle eject request |
| eject_slot_o | output | 5 | Slot to eject, valid with eject_req_o |
| gpe_set_o | output | 1 | Strobe that sets the hotplug bit of the GPE status |

## Verification
The assertions assume that evt_slot_i is always below the slot count and that evt_kind_i is meaningful only while evt_valid_i is high. They also assume that a read of a word is never issued in the same cycle as a write to that word, because the read then returns the old value. The stimulus drives every event with a slot from 0 to 31, holds the kind at zero whenever no event is present, and separates each write from the read that checks it by at least one cycle. The only same-cycle collision it creates on purpose is an event paired with a bitmap write, which is the case R12 defines.

// File: rtl/hp_pkg.sv
package hp_pkg;
  typedef enum logic [1:0] {
    HP_NONE   = 2'd0,
    HP_INSERT = 2'd1,
    HP_REMOVE = 2'd2,
    HP_COLD   = 2'd3
  } hp_kind_e;

  localparam int unsigned W_UP    = 0;
  localparam int unsigned W_DOWN  = 1;
  localparam int unsigned W_EJECT = 2;
  localparam int unsigned W_RMV   = 3;
endpackage

// File: rtl/hp_event_bitmaps.sv
module hp_event_bitmaps
  import hp_pkg::*;
#(
  parameter int unsigned NSLOTS = 32,
  parameter int unsigned SLOT_W = $clog2(NSLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_valid_i,
  input  logic [1:0]        evt_kind_i,
  input  logic [SLOT_W-1:0] evt_slot_i,
  input  logic              wr_up_i,
  input  logic              wr_down_i,
  input  logic [NSLOTS-1:0] wdata_i,
  output logic [NSLOTS-1:0] up_o,
  output logic [NSLOTS-1:0] down_o,
  output logic              gpe_set_o
);
  logic [NSLOTS-1:0] up_q, down_q, slot_bit;
  logic              is_ins, is_rem, live_evt;
  logic              gpe_q;

  assign is_ins   = evt_valid_i && (evt_kind_i == HP_INSERT);
  assign is_rem   = evt_valid_i && (evt_kind_i == HP_REMOVE);
  assign live_evt = is_ins || is_rem;
  assign slot_bit = NSLOTS'(1) << evt_slot_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q   <= '0;
      down_q <= '0;
      gpe_q  <= 1'b0;
    end else if (live_evt) begin
      // event outranks any same-cycle software write
      up_q   <= is_ins ? slot_bit : '0;
      down_q <= is_rem ? slot_bit : '0;
      gpe_q  <= 1'b1;
    end else begin
      gpe_q <= 1'b0;
      if (wr_up_i)   up_q   <= wdata_i;
      if (wr_down_i) down_q <= wdata_i;
    end
  end

  assign up_o      = up_q;
  assign down_o    = down_q;
  assign gpe_set_o = gpe_q;

  p_insert_marks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_kind_i == HP_INSERT) |=>
      (up_o == (NSLOTS'(1) << $past(evt_slot_i))) && (down_o == '0));

  p_remove_marks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_kind_i == HP_REMOVE) |=>
      (down_o == (NSLOTS'(1) << $past(evt_slot_i))) && (up_o == '0));

  p_gpe_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && (evt_kind_i == HP_INSERT || evt_kind_i == HP_REMOVE)) |=> gpe_set_o);

  p_gpe_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_valid_i && (evt_kind_i == HP_INSERT || evt_kind_i == HP_REMOVE)) |=> !gpe_set_o);

  p_cold_silent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_kind_i == HP_COLD && !wr_up_i && !wr_down_i) |=>
      ($stable(up_o) && $stable(down_o)));
endmodule

// File: rtl/hp_eject.sv
module hp_eject #(
  parameter int unsigned NSLOTS = 32,
  parameter int unsigned SLOT_W = $clog2(NSLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [NSLOTS-1:0] wdata_i,
  input  logic [NSLOTS-1:0] rmv_i,
  output logic              eject_req_o,
  output logic [SLOT_W-1:0] eject_slot_o
);
  logic              hit;
  logic [SLOT_W-1:0] idx;
  logic              req_q;
  logic [SLOT_W-1:0] slot_q;

  // lowest set bit: scan downward, last match wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NSLOTS - 1; i >= 0; i--) begin
      if (wdata_i[i]) begin
        hit = 1'b1;
        idx = SLOT_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      slot_q <= '0;
    end else begin
      req_q <= wr_i && hit && rmv_i[idx];
      if (wr_i) slot_q <= idx;
    end
  end

  assign eject_req_o  = req_q;
  assign eject_slot_o = slot_q;

  p_eject_from_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eject_req_o |-> ($past(wr_i) && (($past(wdata_i) >> eject_slot_o) & NSLOTS'(1)) != '0));

  p_eject_lowest_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eject_req_o |-> (($past(wdata_i) & ((NSLOTS'(1) << eject_slot_o) - NSLOTS'(1))) == '0));

  p_eject_capable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eject_req_o |-> rmv_i[eject_slot_o]);

  p_eject_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i == '0) |=> !eject_req_o);
endmodule

// File: rtl/hp_read_mux.sv
module hp_read_mux
  import hp_pkg::*;
#(
  parameter int unsigned NSLOTS = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORD_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [NSLOTS-1:0] up_i,
  input  logic [NSLOTS-1:0] down_i,
  input  logic [NSLOTS-1:0] rmv_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] sel, rdata_q;

  always_comb begin
    case (word_i)
      WORD_W'(W_UP):   sel = DATA_W'(up_i);
      WORD_W'(W_DOWN): sel = DATA_W'(down_i);
      WORD_W'(W_RMV):  sel = DATA_W'(rmv_i);
      default:         sel = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= sel;
  end

  assign rdata_o = rdata_q;

  p_eject_reads_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && word_i == WORD_W'(W_EJECT)) |=> (rdata_o == '0));

  p_hold_without_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/slot_hp_regs.sv
module slot_hp_regs
  import hp_pkg::*;
#(
  parameter int unsigned       NSLOTS     = 32,
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       WORD_W     = 3,
  parameter logic [NSLOTS-1:0] FIXED_MASK = NSLOTS'(3),
  localparam int unsigned      SLOT_W     = $clog2(NSLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_valid_i,
  input  logic [1:0]        evt_kind_i,
  input  logic [SLOT_W-1:0] evt_slot_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [WORD_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              eject_req_o,
  output logic [SLOT_W-1:0] eject_slot_o,
  output logic              gpe_set_o
);
  logic              wr_up, wr_down, wr_ej;
  logic [NSLOTS-1:0] up, down, rmv_q, wslots;

  assign wr_up   = wr_i && (addr_i == WORD_W'(W_UP));
  assign wr_down = wr_i && (addr_i == WORD_W'(W_DOWN));
  assign wr_ej   = wr_i && (addr_i == WORD_W'(W_EJECT));
  assign wslots  = wdata_i[NSLOTS-1:0];

  // removable mask: fixed at reset, no write path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rmv_q <= ~FIXED_MASK;
    else         rmv_q <= rmv_q;
  end

  hp_event_bitmaps #(.NSLOTS(NSLOTS), .SLOT_W(SLOT_W)) u_maps (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_valid_i(evt_valid_i),
    .evt_kind_i (evt_kind_i),
    .evt_slot_i (evt_slot_i),
    .wr_up_i    (wr_up),
    .wr_down_i  (wr_down),
    .wdata_i    (wslots),
    .up_o       (up),
    .down_o     (down),
    .gpe_set_o  (gpe_set_o)
  );

  hp_eject #(.NSLOTS(NSLOTS), .SLOT_W(SLOT_W)) u_eject (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_ej),
    .wdata_i     (wslots),
    .rmv_i       (rmv_q),
    .eject_req_o (eject_req_o),
    .eject_slot_o(eject_slot_o)
  );

  hp_read_mux #(.NSLOTS(NSLOTS), .DATA_W(DATA_W), .WORD_W(WORD_W)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd_i),
    .word_i (addr_i),
    .up_i   (up),
    .down_i (down),
    .rmv_i  (rmv_q),
    .rdata_o(rdata_o)
  );

  p_rmv_fixed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(rmv_q));

  p_event_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_kind_i == HP_INSERT && wr_up) |=>
      (up == (NSLOTS'(1) << $past(evt_slot_i))));
endmodule

// File: tb/slot_hp_regs_test.sv
module slot_hp_regs_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        evt_valid_i = 1'b0;
  logic [1:0]  evt_kind_i = 2'd0;
  logic [4:0]  evt_slot_i = 5'd0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [2:0]  addr_i = 3'd0;
  logic [31:0] wdata_i = 32'd0;
  logic [31:0] rdata_o;
  logic        eject_req_o;
  logic [4:0]  eject_slot_o;
  logic        gpe_set_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  slot_hp_regs uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .evt_valid_i(evt_valid_i), .evt_kind_i(evt_kind_i), .evt_slot_i(evt_slot_i),
    .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .eject_req_o(eject_req_o), .eject_slot_o(eject_slot_o),
    .gpe_set_o(gpe_set_o)
  );

  // row: kind[71:70] slot[69:65] exp_up[64:33] exp_down[32:1] exp_gpe[0]
  localparam int NROWS = 6;
  localparam logic [71:0] ROWS [NROWS] = '{
    {2'd1, 5'd3,  32'h0000_0008, 32'h0000_0000, 1'b1},
    {2'd1, 5'd7,  32'h0000_0080, 32'h0000_0000, 1'b1},
    {2'd2, 5'd7,  32'h0000_0000, 32'h0000_0080, 1'b1},
    {2'd3, 5'd9,  32'h0000_0000, 32'h0000_0080, 1'b0},
    {2'd2, 5'd31, 32'h0000_0000, 32'h8000_0000, 1'b1},
    {2'd1, 5'd0,  32'h0000_0001, 32'h0000_0000, 1'b1}
  };

  localparam logic [31:0] RMV_EXP = 32'hFFFF_FFFC;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0; wdata_i = 32'd0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    rd_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic fire(input logic [1:0] k, input logic [4:0] s);
    @(negedge clk_i);
    evt_valid_i = 1'b1; evt_kind_i = k; evt_slot_i = s;
    @(negedge clk_i);
    evt_valid_i = 1'b0; evt_kind_i = 2'd0; evt_slot_i = 5'd0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 eject", {31'd0, eject_req_o}, 32'd0);
    chk("R1 gpe", {31'd0, gpe_set_o}, 32'd0);
    reg_rd(3'd0, v); chk("R1 up", v, 32'd0);
    reg_rd(3'd1, v); chk("R1 down", v, 32'd0);
    reg_rd(3'd3, v); chk("R1 rmv", v, RMV_EXP);

    // event table: R5 insert, R6 remove, R7 strobe, R8 cold-plug
    for (int i = 0; i < NROWS; i++) begin
      fire(ROWS[i][71:70], ROWS[i][69:65]);
      chk("R7 gpe", {31'd0, gpe_set_o}, {31'd0, ROWS[i][0]});
      @(negedge clk_i);
      chk("R7 gpe falls", {31'd0, gpe_set_o}, 32'd0);
      reg_rd(3'd0, v);
      chk(ROWS[i][71:70] == 2'd3 ? "R8 up" : (ROWS[i][71:70] == 2'd1 ? "R5 up" : "R6 up"), v, ROWS[i][64:33]);
      reg_rd(3'd1, v);
      chk(ROWS[i][71:70] == 2'd3 ? "R8 down" : (ROWS[i][71:70] == 2'd1 ? "R5 down" : "R6 down"), v, ROWS[i][32:1]);
    end

    // R2 software bitmap access
    reg_wr(3'd0, 32'h1234_5678);
    reg_wr(3'd1, 32'hA5A5_0000);
    reg_rd(3'd0, v); chk("R2 up", v, 32'h1234_5678);
    reg_rd(3'd1, v); chk("R2 down", v, 32'hA5A5_0000);

    // R3 zero reads
    reg_rd(3'd2, v); chk("R3 eject word", v, 32'd0);
    reg_rd(3'd4, v); chk("R3 word4", v, 32'd0);
    reg_rd(3'd7, v); chk("R3 word7", v, 32'd0);

    // R4 mask ignores writes
    reg_wr(3'd3, 32'h0000_0000);
    reg_rd(3'd3, v); chk("R4 rmv", v, RMV_EXP);

    // R9 eject decode
    reg_wr(3'd2, 32'h0000_000C);
    chk("R9 req", {31'd0, eject_req_o}, 32'd1);
    chk("R9 slot", {27'd0, eject_slot_o}, 32'd2);
    @(negedge clk_i);
    chk("R9 pulse ends", {31'd0, eject_req_o}, 32'd0);
    reg_wr(3'd2, 32'h8000_0000);
    chk("R9 req31", {31'd0, eject_req_o}, 32'd1);
    chk("R9 slot31", {27'd0, eject_slot_o}, 32'd31);

    // R10 fixed slots refused; lowest bit picks a fixed slot
    reg_wr(3'd2, 32'h0000_0001);
    chk("R10 slot0", {31'd0, eject_req_o}, 32'd0);
    reg_wr(3'd2, 32'h0000_0006);
    chk("R10 slot1 lowest", {31'd0, eject_req_o}, 32'd0);

    // R11 zero write
    reg_wr(3'd2, 32'h0000_0000);
    chk("R11 zero", {31'd0, eject_req_o}, 32'd0);

    // R12 event beats same-cycle bitmap writes
    @(negedge clk_i);
    evt_valid_i = 1'b1; evt_kind_i = 2'd1; evt_slot_i = 5'd5;
    wr_i = 1'b1; addr_i = 3'd0; wdata_i = 32'hFFFF_FFFF;
    @(negedge clk_i);
    evt_valid_i = 1'b0; evt_kind_i = 2'd0; evt_slot_i = 5'd0;
    wr_i = 1'b0; wdata_i = 32'd0;
    reg_rd(3'd0, v); chk("R12 up", v, 32'h0000_0020);
    @(negedge clk_i);
    evt_valid_i = 1'b1; evt_kind_i = 2'd2; evt_slot_i = 5'd6;
    wr_i = 1'b1; addr_i = 3'd0; wdata_i = 32'hFFFF_FFFF;
    @(negedge clk_i);
    evt_valid_i = 1'b0; evt_kind_i = 2'd0; evt_slot_i = 5'd0;
    wr_i = 1'b0; wdata_i = 32'd0;
    reg_rd(3'd0, v); chk("R12 up cleared", v, 32'd0);
    reg_rd(3'd1, v); chk("R12 down", v, 32'h0000_0040);

    // R8 cold-plug after bitmaps hold data
    fire(2'd3, 5'd12);
    chk("R8 gpe", {31'd0, gpe_set_o}, 32'd0);
    reg_rd(3'd1, v); chk("R8 down kept", v, 32'h0000_0040);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule